// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides, for an in-order five-stage integer pipeline, where the execute stage should take its operands from. It compares the two source register numbers of the instruction now in execute with the destination register numbers of the two older instructions, which sit in the memory-access stage and the write-back stage. For each ALU operand it returns a 2-bit select. The select chooses the register-file read value, the ALU result held after execute, or the value about to be written back. The destination compared depends on the class of the producing instruction. A load writes the register named in its rt field. A register-register ALU operation writes the one named in its rd field.

Store data gets its own bypass flags. A store in execute takes its data register from the write-back value when the write-back instruction produces that register. A store in the memory stage can take the same write-back value one cycle later. That second bypass applies only when the first one is not already in use. All logic is combinational. The block sits between the pipeline registers and the operand multiplexers, and it holds no state.

Top module: `fwd_unit`

## Requirements
- R1: The destination compared for a producer is chosen by its class. Class codes are 2'b00 other, 2'b01 ALU, 2'b10 load and 2'b11 store. A load (2'b10) is compared on its rt field and an ALU operation (2'b01) on its rd field.
- R2: A producer is considered only when its write flag is 1. With the flag at 0, a matching register number leaves the select at 2'b00.
- R3: Each operand select uses the code 2'b00 for the register file, 2'b10 for the memory-stage ALU result and 2'b01 for the write-back value. The code 2'b11 never appears.
- R4: When only the write-back producer matches a source register, that operand's select is 2'b01.
- R5: When both producers match the same source register, the memory-stage producer wins and the select is 2'b10.
- R6: A producer of class store or other never causes any forwarding, even with its write flag at 1.
- R7: A source or destination register number of 0 never forwards. All selects and store flags stay at 0 for register 0.
- R8: When the execute instruction is a store (2'b11) and its rt field matches a valid write-back producer, the execute-stage store flag is 1.
- R9: When the memory-stage instruction is a store whose rt field matches a valid write-back producer, the memory-stage store flag is 1. It stays at 0 whenever the execute-stage store flag is 1.
- R10: All-zero inputs give all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | 5 | First source register of the execute instruction |
| ex_rt | input | 5 | Second source register (store data register) of the execute instruction |
| ex_cls | input | 2 | Class of the execute instruction |
| mem_cls | input | 2 | Class of the memory-stage instruction |
| mem_we | input | 1 | Register write flag of the memory-stage instruction |
| mem_rt | input | 5 | rt field of the memory-stage instruction |
| mem_rd | input | 5 | rd field of the memory-stage instruction |
| wb_cls | input | 2 | Class of the write-back instruction |
| wb_we | input | 1 | Register write flag of the write-back instruction |
| wb_rt | input | 5 | rt field of the write-back instruction |
| wb_rd | input | 5 | rd field of the write-back instruction |
| fwd_a | output | 2 | Select for ALU operand A |
| fwd_b | output | 2 | Select for ALU operand B |
| st_byp_ex | output | 1 | Bypass write-back value into store data leaving execute |
| st_byp_mem | output | 1 | Bypass write-back value into store data in the memory stage |

## Verification
The bench goes after the cases where both older instructions write the same register. A design that got the priority backwards would feed the ALU a value that is one instruction stale. It also sets rt and rd of a producer to different registers, so a unit that compared the wrong field for a load would forward on the wrong operand. Register 0, a cleared write flag and store-class producers are each driven with otherwise matching fields, because a unit that ignored any of them would forward garbage into the ALU. Two stores that both want the write-back value show whether the memory-stage store bypass is correctly held off. Random fields then check the outputs against a priority model built from the requirements.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int REG_AW  = 5;
    localparam int CLS_W   = 2;
    localparam int SEL_W   = 2;
    localparam int N_OPND  = 2;

    typedef logic [REG_AW-1:0] regnum_t;

    typedef enum logic [CLS_W-1:0] {
        CLS_OTHER = 2'b00,
        CLS_ALU   = 2'b01,
        CLS_LOAD  = 2'b10,
        CLS_STORE = 2'b11
    } ins_cls_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        ins_cls_e cls;
        logic     we;
        regnum_t  rt;
        regnum_t  rd;
    } producer_t;

    function automatic logic cls_writes(input ins_cls_e c);
        return (c == CLS_ALU) || (c == CLS_LOAD);
    endfunction

    function automatic regnum_t dest_field(input producer_t p);
        return (p.cls == CLS_LOAD) ? p.rt : p.rd;
    endfunction

endpackage

// File: rtl/fwd_dest_pick.sv
module fwd_dest_pick
    import fwd_pkg::*;
(
    input  producer_t prod,
    output regnum_t   dest,
    output logic      valid
);
    always_comb begin
        dest  = dest_field(prod);
        valid = prod.we && cls_writes(prod.cls) && (dest != '0);
    end
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import fwd_pkg::*;
(
    input  regnum_t  src,
    input  regnum_t  mem_dest,
    input  logic     mem_vld,
    input  regnum_t  wb_dest,
    input  logic     wb_vld,
    output fwd_sel_e sel
);
    logic hit_mem;
    logic hit_wb;

    always_comb begin
        hit_mem = mem_vld && (mem_dest == src);
        hit_wb  = wb_vld  && (wb_dest  == src);
        if (hit_mem)
            sel = SEL_MEM;
        else if (hit_wb)
            sel = SEL_WB;
        else
            sel = SEL_RF;
    end

    // R7: producers marked valid never carry register 0, so a zero source stays on the file
    always_comb begin
        a_r7_zero_src_rf: assert (!(src == '0) || sel == SEL_RF)
            else $error("R7: register 0 selected a bypass");
    end
endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel
    import fwd_pkg::*;
(
    input  ins_cls_e ex_cls,
    input  regnum_t  ex_rt,
    input  ins_cls_e mem_cls,
    input  regnum_t  mem_rt,
    input  regnum_t  wb_dest,
    input  logic     wb_vld,
    output logic     byp_ex,
    output logic     byp_mem
);
    always_comb begin
        byp_ex  = (ex_cls == CLS_STORE) && (ex_rt != '0)
                  && wb_vld && (wb_dest == ex_rt);
        byp_mem = (mem_cls == CLS_STORE) && (mem_rt != '0) && !byp_ex
                  && wb_vld && (wb_dest == mem_rt);
    end

    // R8: the execute-stage store bypass needs a producer that really writes
    always_comb begin
        a_r8_ex_needs_producer: assert (!byp_ex || wb_vld)
            else $error("R8: store bypass without a valid producer");
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
(
    input  logic [4:0] ex_rs,
    input  logic [4:0] ex_rt,
    input  logic [1:0] ex_cls,
    input  logic [1:0] mem_cls,
    input  logic       mem_we,
    input  logic [4:0] mem_rt,
    input  logic [4:0] mem_rd,
    input  logic [1:0] wb_cls,
    input  logic       wb_we,
    input  logic [4:0] wb_rt,
    input  logic [4:0] wb_rd,
    output logic [1:0] fwd_a,
    output logic [1:0] fwd_b,
    output logic       st_byp_ex,
    output logic       st_byp_mem
);
    producer_t mem_p;
    producer_t wb_p;
    regnum_t   mem_dest;
    regnum_t   wb_dest;
    logic      mem_vld;
    logic      wb_vld;
    regnum_t   src   [N_OPND];
    fwd_sel_e  sel   [N_OPND];

    always_comb begin
        mem_p = '{cls: ins_cls_e'(mem_cls), we: mem_we, rt: mem_rt, rd: mem_rd};
        wb_p  = '{cls: ins_cls_e'(wb_cls),  we: wb_we,  rt: wb_rt,  rd: wb_rd};
        src[0] = ex_rs;
        src[1] = ex_rt;
    end

    fwd_dest_pick u_mem_pick (.prod(mem_p), .dest(mem_dest), .valid(mem_vld));
    fwd_dest_pick u_wb_pick  (.prod(wb_p),  .dest(wb_dest),  .valid(wb_vld));

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        fwd_operand_sel u_sel (
            .src      (src[g]),
            .mem_dest (mem_dest),
            .mem_vld  (mem_vld),
            .wb_dest  (wb_dest),
            .wb_vld   (wb_vld),
            .sel      (sel[g])
        );
    end

    fwd_store_sel u_store (
        .ex_cls   (ins_cls_e'(ex_cls)),
        .ex_rt    (ex_rt),
        .mem_cls  (ins_cls_e'(mem_cls)),
        .mem_rt   (mem_rt),
        .wb_dest  (wb_dest),
        .wb_vld   (wb_vld),
        .byp_ex   (st_byp_ex),
        .byp_mem  (st_byp_mem)
    );

    always_comb begin
        fwd_a = sel[0];
        fwd_b = sel[1];
    end

    // Port-level checks against the raw pipeline fields
    always_comb begin
        // R2: a memory-stage bypass requires the memory-stage write flag
        a_r2_mem_needs_we: assert (!(fwd_a == SEL_MEM || fwd_b == SEL_MEM) || mem_we)
            else $error("R2: bypass from a non-writing producer");
        // R6: write-back bypass only from load or ALU classes
        a_r6_wb_class: assert (!(fwd_a == SEL_WB || fwd_b == SEL_WB)
                               || wb_cls == CLS_ALU || wb_cls == CLS_LOAD)
            else $error("R6: bypass from a non-writing class");
        // R3: the unused select code never leaves the block
        a_r3_no_code11: assert (fwd_a != 2'b11 && fwd_b != 2'b11)
            else $error("R3: reserved select code");
        // R9: memory-stage store bypass belongs to a store in that stage
        a_r9_mem_store: assert (!st_byp_mem || (mem_cls == CLS_STORE && wb_we))
            else $error("R9: memory store bypass without a store");
    end
endmodule

// File: tb/tb_fwd_unit.sv
`timescale 1ns/1ps
module tb_fwd_unit;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [4:0] ex_rs, ex_rt, mem_rt, mem_rd, wb_rt, wb_rd;
    logic [1:0] ex_cls, mem_cls, wb_cls;
    logic       mem_we, wb_we;
    logic [1:0] fwd_a, fwd_b;
    logic       st_byp_ex, st_byp_mem;

    int n_chk  = 0;
    int n_fail = 0;

    fwd_unit dut (
        .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_cls(ex_cls),
        .mem_cls(mem_cls), .mem_we(mem_we), .mem_rt(mem_rt), .mem_rd(mem_rd),
        .wb_cls(wb_cls), .wb_we(wb_we), .wb_rt(wb_rt), .wb_rd(wb_rd),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .st_byp_ex(st_byp_ex), .st_byp_mem(st_byp_mem)
    );

    // {ex_rs, ex_rt, ex_cls, mem_cls, mem_we, mem_rt, mem_rd,
    //  wb_cls, wb_we, wb_rt, wb_rd, exp_a, exp_b, exp_se, exp_sm}
    localparam int NV = 12;
    localparam logic [43:0] VEC [NV] = '{
        // R3 ALU producer in MEM matches rs
        {5'd3, 5'd4, 2'b01, 2'b01, 1'b1, 5'd9, 5'd3, 2'b00, 1'b0, 5'd0, 5'd0, 2'b10, 2'b00, 1'b0, 1'b0},
        // R4 only WB matches rt
        {5'd3, 5'd4, 2'b01, 2'b00, 1'b0, 5'd0, 5'd0, 2'b01, 1'b1, 5'd0, 5'd4, 2'b00, 2'b01, 1'b0, 1'b0},
        // R5 both match rs, MEM wins
        {5'd5, 5'd7, 2'b01, 2'b01, 1'b1, 5'd0, 5'd5, 2'b01, 1'b1, 5'd0, 5'd5, 2'b10, 2'b00, 1'b0, 1'b0},
        // R1 load in MEM compared on rt, its rd ignored
        {5'd3, 5'd6, 2'b01, 2'b10, 1'b1, 5'd6, 5'd3, 2'b00, 1'b0, 5'd0, 5'd0, 2'b00, 2'b10, 1'b0, 1'b0},
        // R1 load in WB compared on rt
        {5'd1, 5'd2, 2'b01, 2'b00, 1'b0, 5'd0, 5'd0, 2'b10, 1'b1, 5'd2, 5'd1, 2'b00, 2'b01, 1'b0, 1'b0},
        // R2 write flag low blocks a match
        {5'd3, 5'd4, 2'b01, 2'b01, 1'b0, 5'd0, 5'd3, 2'b01, 1'b0, 5'd0, 5'd4, 2'b00, 2'b00, 1'b0, 1'b0},
        // R7 register 0 everywhere
        {5'd0, 5'd0, 2'b11, 2'b01, 1'b1, 5'd0, 5'd0, 2'b01, 1'b1, 5'd0, 5'd0, 2'b00, 2'b00, 1'b0, 1'b0},
        // R8 store in EX takes WB value
        {5'd2, 5'd8, 2'b11, 2'b00, 1'b0, 5'd0, 5'd0, 2'b01, 1'b1, 5'd0, 5'd8, 2'b00, 2'b01, 1'b1, 1'b0},
        // R9 store in MEM takes WB load value
        {5'd1, 5'd2, 2'b01, 2'b11, 1'b0, 5'd9, 5'd0, 2'b10, 1'b1, 5'd9, 5'd0, 2'b00, 2'b00, 1'b0, 1'b1},
        // R9 both stores want it, EX bypass suppresses MEM bypass
        {5'd1, 5'd9, 2'b11, 2'b11, 1'b0, 5'd9, 5'd0, 2'b01, 1'b1, 5'd0, 5'd9, 2'b00, 2'b01, 1'b1, 1'b0},
        // R6 store-class producers never forward
        {5'd3, 5'd4, 2'b01, 2'b11, 1'b1, 5'd3, 5'd3, 2'b11, 1'b1, 5'd4, 5'd4, 2'b00, 2'b00, 1'b0, 1'b0},
        // R7 store to register 0 with a zero-destination producer
        {5'd0, 5'd0, 2'b11, 2'b00, 1'b0, 5'd0, 5'd0, 2'b01, 1'b1, 5'd0, 5'd0, 2'b00, 2'b00, 1'b0, 1'b0}
    };

    function automatic logic [5:0] ref_model(
        input logic [4:0] rs, rt, input logic [1:0] ec,
        input logic [1:0] mc, input logic mw, input logic [4:0] mrt, mrd,
        input logic [1:0] wc, input logic ww, input logic [4:0] wrt, wrd);
        logic [4:0] md, wd;
        logic mv, wv, se, sm;
        logic [1:0] a, b;
        md = (mc == 2'b10) ? mrt : mrd;
        wd = (wc == 2'b10) ? wrt : wrd;
        mv = mw && (mc == 2'b01 || mc == 2'b10) && md != 0;
        wv = ww && (wc == 2'b01 || wc == 2'b10) && wd != 0;
        a  = (mv && md == rs) ? 2'b10 : (wv && wd == rs) ? 2'b01 : 2'b00;
        b  = (mv && md == rt) ? 2'b10 : (wv && wd == rt) ? 2'b01 : 2'b00;
        se = (ec == 2'b11) && rt != 0 && wv && wd == rt;
        sm = (mc == 2'b11) && mrt != 0 && !se && wv && wd == mrt;
        return {a, b, se, sm};
    endfunction

    task automatic check(input string req, input logic [5:0] exp);
        logic [5:0] got;
        got = {fwd_a, fwd_b, st_byp_ex, st_byp_mem};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got a=%b b=%b se=%b sm=%b expected a=%b b=%b se=%b sm=%b",
                     req, got[5:4], got[3:2], got[1], got[0],
                     exp[5:4], exp[3:2], exp[1], exp[0]);
        end
    endtask

    task automatic drive(input logic [37:0] v);
        @(negedge clk);
        {ex_rs, ex_rt, ex_cls, mem_cls, mem_we, mem_rt, mem_rd,
         wb_cls, wb_we, wb_rt, wb_rd} = v;
        #2;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        ex_rs = '0; ex_rt = '0; ex_cls = '0; mem_cls = '0; mem_we = 1'b0;
        mem_rt = '0; mem_rd = '0; wb_cls = '0; wb_we = 1'b0; wb_rt = '0; wb_rd = '0;
        repeat (3) @(posedge clk);
        #2;
        check("R10 idle", 6'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][43:6]);
            check($sformatf("R1-table vector %0d", i), VEC[i][5:0]);
        end

        // R5 priority also on operand B with a load in MEM and ALU in WB
        drive({5'd4, 5'd6, 2'b01, 2'b10, 1'b1, 5'd6, 5'd1, 2'b01, 1'b1, 5'd0, 5'd6});
        check("R5 operand B", {2'b00, 2'b10, 1'b0, 1'b0});

        // Random sweep against the priority model, small register range for collisions
        for (int i = 0; i < 3000; i++) begin
            logic [37:0] v;
            v = {5'($urandom_range(0, 5)), 5'($urandom_range(0, 5)), 2'($urandom),
                 2'($urandom), 1'($urandom), 5'($urandom_range(0, 5)), 5'($urandom_range(0, 5)),
                 2'($urandom), 1'($urandom), 5'($urandom_range(0, 5)), 5'($urandom_range(0, 5))};
            drive(v);
            check("R3 random", ref_model(v[37:33], v[32:28], v[27:26], v[25:24], v[23],
                                         v[22:18], v[17:13], v[12:11], v[10], v[9:5], v[4:0]));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule